// File: doc/BRIEF.md
# HDLC Transmit Framer

This block turns a stream of frame octets, offered over a valid/ready interface, into a synchronous serial HDLC line. Every frame is wrapped in 0x7E delimiter octets. Its address, control and payload octets are sent least-significant bit first. A frame check sequence follows them, 16 or 32 bits long and most-significant bit first. Between the delimiters, a zero is inserted after every run of five ones, so that the delimiter pattern never appears inside a frame.

The bit rate is set by an external bit clock, which reaches the block as a one-cycle enable strobe `bit_en` in the system clock domain. Each strobe moves one line bit out on `tx_bit`. When no frame is waiting, the block sends back-to-back delimiters. When a new frame is waiting at the end of a closing delimiter, that delimiter also serves as the opening delimiter of the next frame.

Top module: `hdlc_tx_framer`

## Requirements
- R1: Out of reset, `tx_bit` is 1 and `in_ready` is 0. With no frame pending, the line carries an unbroken repetition of the delimiter 0x7E sent LSB first (bit order 0,1,1,1,1,1,1,0).
- R2: `in_ready` is high only in a cycle with `bit_en` high, and only in the slot that sends the last bit of a delimiter or of a non-final octet. An octet is taken when `in_valid` and `in_ready` are both high. `in_last` marks the final octet of a frame.
- R3: Octets are sent least-significant bit first and in the order they were accepted. After stuffed zeros are removed, the frame body holds exactly these bits, followed by the check sequence.
- R4: Between the delimiters, a 0 is inserted after five consecutive 1s. Any 0 clears the run count. Delimiter bits do not count toward the run. The line never carries seven 1s in a row, and it carries six 1s only inside a delimiter.
- R5: `in_ready` stays low in any slot that carries an inserted zero.
- R6: The 16-bit check sequence uses the generator x^16+x^12+x^5+1 (0x1021) with an all-ones preset. It covers only the octet bits, in line order. The complemented remainder is sent with its highest-order coefficient first.
- R7: The 32-bit check sequence uses generator 0x04C11DB7 with an all-ones preset. It is complemented and sent highest-order coefficient first, with the same coverage as R6.
- R8: `crc32_sel` (1 = 32-bit, 0 = 16-bit) is sampled only when the first octet of a frame is accepted. Changes to it later in the frame have no effect on that frame.
- R9: If the first octet of the next frame is already offered when a closing delimiter ends, exactly one delimiter separates the two frames.
- R10: `tx_bit` changes only on a clock edge at which `bit_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle strobe per line bit |
| crc32_sel | input | 1 | Check sequence length for the next frame: 1 = 32 bits, 0 = 16 bits |
| in_valid | input | 1 | Source offers an octet |
| in_data | input | OCT_W | Offered octet |
| in_last | input | 1 | Offered octet is the last of its frame |
| in_ready | output | 1 | Octet is taken in this cycle |
| tx_bit | output | 1 | Serial line bit |

## Verification
The assertions assume the source behaves as a well-formed valid/ready producer. Once `in_valid` is raised, it stays high, with `in_data` unchanged, until the octet is taken. Inside a frame, the next octet is always already offered when it is asked for. The one-run counter in the checker follows the line from reset, whatever the spacing of the `bit_en` strobes. The bench source holds a queue of octets and advances only after a sampled handshake. It inserts idle gaps only before the first octet of a frame. It keeps `crc32_sel` steady while a first octet waits and randomizes it later in the frame.

// File: rtl/hdlc_tx_framer.sv
`timescale 1ns/1ps
module hdlc_tx_framer #(
  parameter int OCT_W = 8,
  parameter logic [OCT_W-1:0] FLAG_OCT = 8'h7E,
  parameter int RUN_MAX = 5,
  parameter logic [15:0] POLY16_REFL = 16'h8408,
  parameter logic [31:0] POLY32_REFL = 32'hEDB88320
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             crc32_sel,
  input  logic             in_valid,
  input  logic [OCT_W-1:0] in_data,
  input  logic             in_last,
  output logic             in_ready,
  output logic             tx_bit
);
  localparam int IDX_W = $clog2(OCT_W);
  localparam int CNT_W = 6;
  localparam int RUN_W = $clog2(RUN_MAX + 1);

  typedef enum logic [1:0] {ST_FLAG, ST_BODY, ST_FCS} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [OCT_W-1:0] sh;
  logic             last_r, wide_r;
  logic [31:0]      crc, crc_step;
  logic [RUN_W-1:0] ones, ones_nx;
  logic [IDX_W-1:0] idx;
  logic             stuff, oct_end, fcs_end, need, cur, out_bit, fb;

  assign idx      = cnt[IDX_W-1:0];
  assign stuff    = (ones == RUN_W'(RUN_MAX));
  assign oct_end  = (cnt == CNT_W'(OCT_W - 1));
  assign fcs_end  = (cnt == (wide_r ? CNT_W'(31) : CNT_W'(15)));
  assign need     = !stuff && oct_end && (st == ST_FLAG || (st == ST_BODY && !last_r));
  assign in_ready = bit_en && need;

  always_comb begin
    case (st)
      ST_FLAG: cur = FLAG_OCT[idx];
      ST_BODY: cur = sh[idx];
      default: cur = ~crc[0];
    endcase
  end

  assign out_bit  = stuff ? 1'b0 : cur;
  assign ones_nx  = cur ? ones + RUN_W'(1) : '0;
  assign fb       = crc[0] ^ cur;
  assign crc_step = wide_r ? ((crc >> 1) ^ (fb ? POLY32_REFL : 32'h0))
                           : {16'h0, (crc[15:0] >> 1) ^ (fb ? POLY16_REFL : 16'h0)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_FLAG;
      cnt    <= '0;
      sh     <= '0;
      last_r <= 1'b0;
      wide_r <= 1'b0;
      crc    <= '1;
      ones   <= '0;
      tx_bit <= 1'b1;
    end else if (bit_en) begin
      tx_bit <= out_bit;
      if (stuff) begin
        ones <= '0;
      end else begin
        case (st)
          ST_FLAG: begin
            if (oct_end) begin
              cnt <= '0;
              if (in_valid) begin
                sh     <= in_data;
                last_r <= in_last;
                wide_r <= crc32_sel;
                crc    <= '1;
                ones   <= '0;
                st     <= ST_BODY;
              end
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          ST_BODY: begin
            crc  <= crc_step;
            ones <= ones_nx;
            if (oct_end) begin
              cnt <= '0;
              if (!last_r && in_valid) begin
                sh     <= in_data;
                last_r <= in_last;
              end else begin
                st <= ST_FCS;
              end
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          default: begin
            crc  <= {1'b0, crc[31:1]};
            ones <= ones_nx;
            if (fcs_end) begin
              cnt <= '0;
              st  <= ST_FLAG;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/hdlc_tx_framer_sva.sv
`timescale 1ns/1ps
module hdlc_tx_framer_sva #(
  parameter int OCT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_en,
  input logic             in_valid,
  input logic [OCT_W-1:0] in_data,
  input logic             in_ready,
  input logic             tx_bit
);
  logic       en_d;
  logic [3:0] run_q, run_now;

  assign run_now = en_d ? (tx_bit ? ((run_q == 4'hF) ? run_q : run_q + 4'd1) : 4'd0) : run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_d  <= 1'b0;
      run_q <= '0;
    end else begin
      en_d  <= bit_en;
      run_q <= run_now;
    end
  end

  assert_line_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_bit));

  assert_run_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_now <= 4'd6);

  assert_no_take_on_stuff_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (run_now != 4'd5));

  assert_source_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> (in_valid && $stable(in_data)));
endmodule

bind hdlc_tx_framer hdlc_tx_framer_sva #(.OCT_W(OCT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_valid(in_valid),
  .in_data(in_data), .in_ready(in_ready), .tx_bit(tx_bit)
);

// File: tb/sim_hdlc_tx_framer.sv
`timescale 1ns/1ps
module sim_hdlc_tx_framer;
  localparam int NF = 32;
  localparam int QMAX = 1024;
  localparam int LIMIT = 150000;
  localparam logic [7:0] FLAG_PAT = 8'h7E;

  logic clk = 1'b0;
  logic rst_n, bit_en, crc32_sel, in_valid, in_last, in_ready, tx_bit;
  logic [7:0] in_data;

  always #2.5 clk = ~clk;

  hdlc_tx_framer u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .crc32_sel(crc32_sel),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .tx_bit(tx_bit)
  );

  logic [7:0] q [0:QMAX-1];
  int  fstart [0:NF-1];
  int  flen   [0:NF-1];
  int  gap    [0:NF-1];
  bit  fmode  [0:NF-1];
  int  total;

  logic rxbuf [0:QMAX-1];
  int rxn, rxk, ones, idle_flags, init_flags, ipos, stuffed;
  int nchk, nfail, idle_bad, run_bad, r5_bad, r2_bad, r10_bad;
  int ptr, cf, gapcnt, nacc, cyc;
  logic en_q, rdy_q, hs_q, prev_bit;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] calc_fcs(input int start, input int len, input bit wide);
    logic [31:0] r;
    logic b, f;
    r = '1;
    for (int k = 0; k < len; k++) begin
      for (int i = 0; i < 8; i++) begin
        b = q[start + k][i];
        if (wide) begin
          f = r[31] ^ b;
          r = {r[30:0], 1'b0} ^ (f ? 32'h04C11DB7 : 32'h0);
        end else begin
          f = r[15] ^ b;
          r[15:0] = {r[14:0], 1'b0} ^ (f ? 16'h1021 : 16'h0);
        end
      end
    end
    return wide ? ~r : {16'h0, ~r[15:0]};
  endfunction

  task automatic add_frame(input int f, input int len, input bit mode, input int g);
    fstart[f] = total;
    flen[f]   = len;
    fmode[f]  = mode;
    gap[f]    = g;
    total     = total + len;
  endtask

  task automatic finish_frame(input int n);
    int k, nb, mism, fmis;
    logic [31:0] fcs;
    k = rxk;
    if (k >= NF) begin
      chk(1'b0, "R3 extra frame", k, NF);
      return;
    end
    nb = fmode[k] ? 32 : 16;
    mism = 0;
    for (int i = 0; i < flen[k] * 8; i++)
      if (rxbuf[i] !== q[fstart[k] + i / 8][i % 8]) mism++;
    chk(n == flen[k] * 8 + nb && mism == 0, "R3 frame body bits", n, flen[k] * 8 + nb);
    if (n == flen[k] * 8 + nb) begin
      fcs = calc_fcs(fstart[k], flen[k], fmode[k]);
      fmis = 0;
      for (int j = 0; j < nb; j++)
        if (rxbuf[flen[k] * 8 + j] !== fcs[nb - 1 - j]) fmis++;
      if (fmode[k]) chk(fmis == 0, "R7/R8 32-bit check sequence", fmis, 0);
      else          chk(fmis == 0, "R6/R8 16-bit check sequence", fmis, 0);
    end
    if (k > 0 && gap[k] == 0)
      chk(idle_flags == 0, "R9 shared delimiter", idle_flags, 0);
    idle_flags = 0;
    rxk++;
  endtask

  task automatic take_bit(input logic b, input logic rdy);
    if (nacc == 0) begin
      if (b !== FLAG_PAT[ipos % 8]) idle_bad++;
      ipos++;
    end
    if (b) begin
      ones++;
      if (ones > 6) run_bad++;
      if (rxn < QMAX) rxbuf[rxn] = 1'b1;
      rxn++;
    end else begin
      if (ones == 5) begin
        stuffed++;
        if (rdy) r5_bad++;
      end else if (ones == 6) begin
        if (rxn - 7 > 0) finish_frame(rxn - 7);
        else begin
          idle_flags++;
          if (nacc == 0) init_flags++;
        end
        rxn = 0;
      end else begin
        if (rxn < QMAX) rxbuf[rxn] = 1'b0;
        rxn++;
      end
      ones = 0;
    end
  endtask

  initial begin
    int seed, len;
    seed = $urandom(32'd20515);
    total = 0;
    nchk = 0; nfail = 0; idle_bad = 0; run_bad = 0; r5_bad = 0; r2_bad = 0; r10_bad = 0;
    rxn = 0; rxk = 0; ones = 0; idle_flags = 0; init_flags = 0; ipos = 0; stuffed = 0;
    ptr = 0; cf = 0; gapcnt = 0; nacc = 0; cyc = 0;
    en_q = 0; rdy_q = 0; hs_q = 0;

    add_frame(0, 6, 1'b0, 300);
    for (int i = 0; i < 6; i++) q[fstart[0] + i] = 8'hFF;
    add_frame(1, 5, 1'b1, 0);
    q[fstart[1]] = 8'h7E; q[fstart[1]+1] = 8'h7E; q[fstart[1]+2] = 8'h7E;
    q[fstart[1]+3] = 8'h3F; q[fstart[1]+4] = 8'hFC;
    add_frame(2, 1, 1'b0, 0);
    q[fstart[2]] = 8'h00;
    add_frame(3, 1, 1'b1, 5);
    q[fstart[3]] = 8'hFF;
    for (int f = 4; f < NF; f++) begin
      len = 1 + int'($urandom % 24);
      add_frame(f, len, 1'($urandom % 2), ($urandom % 4 == 0) ? 60 : int'($urandom % 3));
      for (int i = 0; i < len; i++)
        q[fstart[f] + i] = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom);
    end

    rst_n = 0; bit_en = 0; crc32_sel = 0; in_valid = 0; in_data = 0; in_last = 0;
    repeat (4) @(negedge clk);
    chk(tx_bit === 1'b1, "R1 reset line level", tx_bit, 1);
    chk(in_ready === 1'b0, "R1 reset ready", in_ready, 0);
    rst_n = 1;
    prev_bit = tx_bit;

    while (rxk < NF && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
      if (en_q) take_bit(tx_bit, rdy_q);
      else if (tx_bit !== prev_bit) r10_bad++;
      prev_bit = tx_bit;
      if (hs_q) begin
        ptr++;
        nacc++;
        if (cf + 1 < NF && ptr == fstart[cf + 1]) begin
          cf++;
          gapcnt = 0;
        end
      end
      bit_en = ($urandom % 3 != 0);
      if (ptr < total) begin
        if (ptr == fstart[cf] && gapcnt < gap[cf]) begin
          in_valid = 0;
          gapcnt++;
        end else begin
          in_valid  = 1;
          in_data   = q[ptr];
          in_last   = (ptr == fstart[cf] + flen[cf] - 1);
          crc32_sel = (ptr == fstart[cf]) ? fmode[cf] : 1'($urandom % 2);
        end
      end else begin
        in_valid = 0;
      end
      #1;
      en_q  = bit_en;
      rdy_q = in_ready;
      hs_q  = in_ready && in_valid;
      if (in_ready && !bit_en) r2_bad++;
    end

    chk(cyc < LIMIT, "R2 watchdog expired", cyc, LIMIT);
    chk(rxk == NF, "R2 frames delivered", rxk, NF);
    chk(nacc == total, "R2 octets accepted", nacc, total);
    chk(r2_bad == 0, "R2 ready outside slot", r2_bad, 0);
    chk(idle_bad == 0, "R1 idle delimiter pattern", idle_bad, 0);
    chk(init_flags >= 10, "R1 idle delimiter count", init_flags, 10);
    chk(run_bad == 0, "R4 ones run limit", run_bad, 0);
    chk(stuffed > 0, "R4 zeros inserted", stuffed, 1);
    chk(r5_bad == 0, "R5 ready on inserted zero", r5_bad, 0);
    chk(r10_bad == 0, "R10 line change without strobe", r10_bad, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule